// File: doc/BRIEF.md
# Segment Selector Load Unit

This block fills one of several segment registers from a 16-bit selector. On a load request it picks the global or the local descriptor table from the selector. It checks the index against that table's limit and fetches the 8-byte descriptor as two 32-bit words over a synchronous read port. It then checks the descriptor's type and presence. If every check passes, it copies the assembled base, the limit and the attribute bits into a hidden cache entry for the target register.

The cache is a snapshot. Later edits to table memory have no effect on it until the same register is loaded again. Each load ends in exactly one single-cycle pulse, either done or fault, with a fault code beside it. A request is accepted only while the unit is idle. The caller waits for the pulse before it issues the next request.

Top module: `seg_load_unit`

## Requirements
- R1: Selector bit 2 picks the table (0 global, 1 local), bits 15:3 are the index and bits 1:0 the requested privilege. The descriptor address is table base + index*8. It is read as two words, at that address and then at address+4.
- R2: A global-table selector with index 0 faults with code 1 and issues no memory read.
- R3: Index 0 of the local table is an ordinary entry and loads like any other.
- R4: If index*8+7 is greater than the chosen table's limit, the load faults with code 2 and issues no memory read. An entry whose last byte equals the limit loads.
- R5: A descriptor read from the local table that is a system descriptor (high word bit 12 clear) with type field (high word bits 11:8) equal to 1, 2, 3, 9 or 11 faults with code 3. The same descriptor is accepted from the global table.
- R6: An executable descriptor (bit 12 set and bit 11 set) faults with code 4 when the target register is marked writable in the WR_MASK parameter (default: registers 1, 2 and 3). It loads into register 0.
- R7: A descriptor whose present bit (high word bit 15) is clear faults with code 5. The checks run in the order R5, R6, R7, and the first one that fails sets the code.
- R8: The base is {hi[31:24], hi[7:0], lo[31:16]}. The raw 20-bit limit is {hi[19:16], lo[15:0]}. When the granularity bit (hi[23]) is set, the cached limit is {raw, 12'hFFF}; otherwise it is the zero-extended raw limit.
- R9: The cached attributes are {selector[1:0], hi[23:20], hi[15:8]}, 14 bits.
- R10: Each accepted load produces exactly one single-cycle pulse, on ld_done with ld_code 0 or on ld_fault with a nonzero ld_code. The two are never high together.
- R11: A fault leaves every cache entry unchanged. A successful load changes only the target register's entry.
- R12: After a load, writes to table memory do not change the cached values until that register is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load request, sampled while idle |
| ld_sel | input | 16 | Selector to load |
| ld_reg | input | REG_W | Target segment register number |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | TLIM_W | Global table limit (last valid byte offset) |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | TLIM_W | Local table limit (last valid byte offset) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| ld_done | output | 1 | One-cycle success pulse |
| ld_fault | output | 1 | One-cycle fault pulse |
| ld_code | output | 3 | Fault code, valid with the pulse |
| seg_base | output | NUM_SEGS*32 | Cached bases, register i at bits [32i+31:32i] |
| seg_limit | output | NUM_SEGS*32 | Cached limits, same packing |
| seg_attr | output | NUM_SEGS*14 | Cached attributes, register i at [14i+13:14i] |

## Verification
A wrong check decision appears at the ports within about five cycles of the request. The pulse carries the wrong code, or memory reads appear where the null and range checks should have stopped the load. A corrupted cache write shows at once on the affected register's base, limit or attribute outputs, and it stays visible until that register is reloaded. Leaks from the table memory into the snapshot are caught by rewriting a loaded descriptor and then watching the outputs before and after the reload.

// File: rtl/seg_pkg.sv
// Shared types for the segment selector load unit.
// Assumes a 32-bit descriptor base and limit; attribute width is fixed at 14.
package seg_pkg;
    localparam int ATTR_W = 14;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_RANGE  = 3'd2,
        FLT_TABLE  = 3'd3,
        FLT_EXEC   = 3'd4,
        FLT_ABSENT = 3'd5
    } fault_e;

    typedef struct packed {
        logic [31:0]       base;
        logic [31:0]       limit;
        logic [ATTR_W-1:0] attr;
    } seg_entry_t;
endpackage

// File: rtl/seg_sel_check.sv
// Selector front check: picks the table, forms the descriptor address and
// flags a null global selector or an index past the table limit.
// Assumes table limits are byte offsets of the last valid byte.
module seg_sel_check #(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16
) (
    input  logic [15:0]        sel,
    input  logic [ADDR_W-1:0]  gdt_base,
    input  logic [TLIM_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0]  ldt_base,
    input  logic [TLIM_W-1:0]  ldt_limit,
    output logic [ADDR_W-1:0]  desc_addr,
    output seg_pkg::fault_e    code
);
    localparam int CMP_W = (TLIM_W > 16) ? TLIM_W : 16;

    logic             use_local;
    logic [12:0]      idx;
    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] tbl_lim;

    // Decode the selector fields and pick the table limit.
    always_comb begin
        use_local = sel[2];
        idx       = sel[15:3];
        last_byte = CMP_W'({idx, 3'b111});
        tbl_lim   = use_local ? CMP_W'(ldt_limit) : CMP_W'(gdt_limit);
        desc_addr = (use_local ? ldt_base : gdt_base) + ADDR_W'({idx, 3'b000});
    end

    // Null global selector first, then range.
    always_comb begin
        if (!use_local && idx == 13'd0)
            code = seg_pkg::FLT_NULL;
        else if (last_byte > tbl_lim)
            code = seg_pkg::FLT_RANGE;
        else
            code = seg_pkg::FLT_NONE;
    end
endmodule

// File: rtl/seg_desc_decode.sv
// Descriptor decode: assembles base, limit and attributes from the two
// fetched words and applies table-type, executable and present checks.
// Assumes lo is the word at the descriptor address and hi the one after.
module seg_desc_decode (
    input  logic [31:0]         lo,
    input  logic [31:0]         hi,
    input  logic                from_local,
    input  logic                wr_target,
    input  logic [1:0]          rpl,
    output seg_pkg::seg_entry_t entry,
    output seg_pkg::fault_e     code
);
    logic [19:0] raw_lim;
    logic [3:0]  dtype;
    logic        is_sys;
    logic        sys_forbidden;
    logic        is_exec;
    logic        present;

    // Assemble the cache entry from the split fields.
    always_comb begin
        raw_lim     = {hi[19:16], lo[15:0]};
        entry.base  = {hi[31:24], hi[7:0], lo[31:16]};
        entry.limit = hi[23] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};
        entry.attr  = {rpl, hi[23:20], hi[15:8]};
    end

    // Classify the descriptor type bits.
    always_comb begin
        dtype         = hi[11:8];
        is_sys        = !hi[12];
        is_exec       = hi[12] && hi[11];
        present       = hi[15];
        sys_forbidden = is_sys && (dtype == 4'd1 || dtype == 4'd2 || dtype == 4'd3 ||
                                   dtype == 4'd9 || dtype == 4'd11);
    end

    // Apply the checks in priority order.
    always_comb begin
        if (from_local && sys_forbidden)
            code = seg_pkg::FLT_TABLE;
        else if (is_exec && wr_target)
            code = seg_pkg::FLT_EXEC;
        else if (!present)
            code = seg_pkg::FLT_ABSENT;
        else
            code = seg_pkg::FLT_NONE;
    end
endmodule

// File: rtl/seg_cache_bank.sv
// Hidden segment cache: one entry per register, written only on a
// successful load; every entry is driven out flat.
// Assumes at most one write per cycle.
module seg_cache_bank #(
    parameter int NUM_SEGS = 4,
    parameter int REG_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [REG_W-1:0]                  wr_idx,
    input  seg_pkg::seg_entry_t               wr_entry,
    output logic [NUM_SEGS*32-1:0]            seg_base,
    output logic [NUM_SEGS*32-1:0]            seg_limit,
    output logic [NUM_SEGS*seg_pkg::ATTR_W-1:0] seg_attr
);
    localparam int AW = seg_pkg::ATTR_W;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        seg_pkg::seg_entry_t ent;

        // Hold the entry; replace it only when this register is loaded.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent <= '0;
            else if (wr_en && wr_idx == REG_W'(g))
                ent <= wr_entry;
        end

        assign seg_base[g*32 +: 32]  = ent.base;
        assign seg_limit[g*32 +: 32] = ent.limit;
        assign seg_attr[g*AW +: AW]  = ent.attr;
    end
endmodule

// File: rtl/seg_load_unit.sv
// Segment selector load unit top: sequences the check, the two-word
// descriptor fetch, the decode and the cache update, and emits one
// done or fault pulse per accepted request.
// Assumes memory returns data one cycle after mem_rd_en.
module seg_load_unit #(
    parameter int                NUM_SEGS = 4,
    parameter int                ADDR_W   = 32,
    parameter int                TLIM_W   = 16,
    parameter logic [NUM_SEGS-1:0] WR_MASK = 4'b1110,
    localparam int               REG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
    localparam int               AW       = seg_pkg::ATTR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_req,
    input  logic [15:0]             ld_sel,
    input  logic [REG_W-1:0]        ld_reg,
    input  logic [ADDR_W-1:0]       gdt_base,
    input  logic [TLIM_W-1:0]       gdt_limit,
    input  logic [ADDR_W-1:0]       ldt_base,
    input  logic [TLIM_W-1:0]       ldt_limit,
    output logic                    mem_rd_en,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [31:0]             mem_rdata,
    output logic                    ld_done,
    output logic                    ld_fault,
    output logic [2:0]              ld_code,
    output logic [NUM_SEGS*32-1:0]  seg_base,
    output logic [NUM_SEGS*32-1:0]  seg_limit,
    output logic [NUM_SEGS*AW-1:0]  seg_attr
);
    typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_EVAL} state_e;

    state_e              state;
    logic [15:0]         sel_q;
    logic [REG_W-1:0]    reg_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [31:0]         lo_q;
    logic [ADDR_W-1:0]   chk_addr;
    seg_pkg::fault_e     chk_code;
    seg_pkg::fault_e     dec_code;
    seg_pkg::seg_entry_t dec_entry;
    logic                cache_we;

    seg_sel_check #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_chk_sel (
        .sel       (sel_q),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .desc_addr (chk_addr),
        .code      (chk_code)
    );

    seg_desc_decode u_dec (
        .lo         (lo_q),
        .hi         (mem_rdata),
        .from_local (sel_q[2]),
        .wr_target  (WR_MASK[reg_q]),
        .rpl        (sel_q[1:0]),
        .entry      (dec_entry),
        .code       (dec_code)
    );

    // Memory port: strobe in the two read states, second word at +4.
    always_comb begin
        mem_rd_en = (state == S_RD_LO) || (state == S_RD_HI);
        mem_addr  = (state == S_RD_HI) ? addr_q + ADDR_W'(4) : addr_q;
    end

    // Cache write on a clean decode in the evaluation state.
    always_comb cache_we = (state == S_EVAL) && (dec_code == seg_pkg::FLT_NONE);

    // Sequencer and result pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sel_q    <= '0;
            reg_q    <= '0;
            addr_q   <= '0;
            lo_q     <= '0;
            ld_done  <= 1'b0;
            ld_fault <= 1'b0;
            ld_code  <= 3'd0;
        end else begin
            ld_done  <= 1'b0;
            ld_fault <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (ld_req) begin
                        sel_q <= ld_sel;
                        reg_q <= ld_reg;
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    addr_q <= chk_addr;
                    if (chk_code != seg_pkg::FLT_NONE) begin
                        ld_fault <= 1'b1;
                        ld_code  <= chk_code;
                        state    <= S_IDLE;
                    end else begin
                        state <= S_RD_LO;
                    end
                end
                S_RD_LO: state <= S_RD_HI;
                S_RD_HI: begin
                    lo_q  <= mem_rdata;
                    state <= S_EVAL;
                end
                S_EVAL: begin
                    ld_code  <= dec_code;
                    ld_done  <= (dec_code == seg_pkg::FLT_NONE);
                    ld_fault <= (dec_code != seg_pkg::FLT_NONE);
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    seg_cache_bank #(.NUM_SEGS(NUM_SEGS), .REG_W(REG_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cache_we),
        .wr_idx    (reg_q),
        .wr_entry  (dec_entry),
        .seg_base  (seg_base),
        .seg_limit (seg_limit),
        .seg_attr  (seg_attr)
    );
endmodule

// File: rtl/seg_load_chk.sv
// Port-level checker for the segment selector load unit; bound to the top.
module seg_load_chk #(
    parameter int NUM_SEGS = 4,
    parameter int AW       = 14
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ld_done,
    input logic                   ld_fault,
    input logic [2:0]             ld_code,
    input logic                   mem_rd_en,
    input logic [NUM_SEGS*32-1:0] seg_base,
    input logic [NUM_SEGS*32-1:0] seg_limit,
    input logic [NUM_SEGS*AW-1:0] seg_attr
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_done && ld_fault));                                          // R10
    AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> ld_code == 3'd0);                                     // R10
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |-> ld_code != 3'd0);                                    // R10
    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_done |-> ($stable(seg_base) && $stable(seg_limit) && $stable(seg_attr))); // R11
    AST_NO_READ_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done || ld_fault) |-> !mem_rd_en);                            // R1
endmodule

bind seg_load_unit seg_load_chk #(.NUM_SEGS(NUM_SEGS), .AW(AW)) u_load_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_done   (ld_done),
    .ld_fault  (ld_fault),
    .ld_code   (ld_code),
    .mem_rd_en (mem_rd_en),
    .seg_base  (seg_base),
    .seg_limit (seg_limit),
    .seg_attr  (seg_attr)
);

// File: tb/seg_load_unit_tb.sv
module seg_load_unit_tb;
    localparam int NS = 4;
    localparam int RW = 2;
    localparam int AW = 14;
    localparam logic [31:0] GB = 32'h100;
    localparam logic [31:0] LB = 32'h400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_req = 1'b0;
    logic [15:0]       ld_sel = '0;
    logic [RW-1:0]     ld_reg = '0;
    logic [31:0]       gdt_base = GB;
    logic [15:0]       gdt_limit = 16'h003F;
    logic [31:0]       ldt_base = LB;
    logic [15:0]       ldt_limit = 16'h001F;
    logic              mem_rd_en;
    logic [31:0]       mem_addr;
    logic [31:0]       mem_rdata = '0;
    logic              ld_done, ld_fault;
    logic [2:0]        ld_code;
    logic [NS*32-1:0]  seg_base, seg_limit;
    logic [NS*AW-1:0]  seg_attr;

    seg_load_unit u_dut (.*);

    always #4 clk = ~clk;

    logic [31:0] mem [0:1023];
    always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];

    typedef struct {
        logic        fault;
        logic [2:0]  code;
        int          rg;
        logic [31:0] base;
        logic [31:0] lim;
        logic [13:0] attr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_base [NS];
    logic [31:0] m_lim  [NS];
    logic [13:0] m_attr [NS];
    int checks = 0, bad = 0, results = 0, rd_cnt = 0, cyc = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] addr, input logic [31:0] b, input logic [19:0] l,
                            input logic [7:0] acc, input logic [3:0] fl);
        mem[addr[11:2]]     = {b[15:0], l[15:0]};
        mem[addr[11:2] + 1] = {b[31:24], fl, l[19:16], acc, b[23:16]};
    endtask

    // Driver: pushes the expected result, issues the request, waits for it.
    task automatic do_load(input string tag, input logic [15:0] sel, input int rg,
                           input logic [2:0] code, input logic [31:0] b, input logic [19:0] l,
                           input logic [7:0] acc, input logic [3:0] fl);
        exp_t e;
        int target;
        e.tag = tag; e.rg = rg; e.code = code; e.fault = (code != 3'd0);
        if (e.fault) begin
            e.base = m_base[rg]; e.lim = m_lim[rg]; e.attr = m_attr[rg];
        end else begin
            e.base = b;
            e.lim  = fl[3] ? {l, 12'hFFF} : {12'd0, l};
            e.attr = {sel[1:0], fl, acc};
            m_base[rg] = e.base; m_lim[rg] = e.lim; m_attr[rg] = e.attr;
        end
        sb.push_back(e);
        target = results + 1;
        @(negedge clk);
        rd_cnt = 0;
        ld_req = 1'b1; ld_sel = sel; ld_reg = RW'(rg);
        @(negedge clk);
        ld_req = 1'b0;
        wait (results == target);
        // R1/R2/R4: reads issued per load
        chk({tag, " reads"}, 64'(rd_cnt), (code == 3'd1 || code == 3'd2) ? 64'd0 : 64'd2);
        @(negedge clk);
        chk({tag, " R10 pulse width"}, {62'd0, ld_done, ld_fault}, 64'd0);
    endtask

    always @(posedge clk) if (mem_rd_en) rd_cnt++;

    // Monitor: pops the scoreboard on each result pulse and compares.
    always @(negedge clk) begin
        if (rst_n && (ld_done || ld_fault)) begin
            exp_t e;
            if (sb.size() == 0) begin
                checks++; bad++;
                $display("FAIL R10 unexpected pulse actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                chk({e.tag, " R10 fault"}, 64'(ld_fault), 64'(e.fault));
                chk({e.tag, " R10 done"},  64'(ld_done),  64'(!e.fault));
                chk({e.tag, " code"}, 64'(ld_code), 64'(e.code));
                for (int i = 0; i < NS; i++) begin
                    chk({e.tag, " R11 base"}, 64'(seg_base[i*32 +: 32]), 64'(m_base[i]));
                    chk({e.tag, " R8 limit"}, 64'(seg_limit[i*32 +: 32]), 64'(m_lim[i]));
                    chk({e.tag, " R9 attr"},  64'(seg_attr[i*AW +: AW]), 64'(m_attr[i]));
                end
            end
            results++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < NS; i++) begin m_base[i] = '0; m_lim[i] = '0; m_attr[i] = '0; end
        put_desc(GB + 8,  32'h1234_5678, 20'h0ABCD, 8'h93, 4'h4);
        put_desc(GB + 16, 32'hA000_0000, 20'hFFFFF, 8'h93, 4'hC);
        put_desc(GB + 24, 32'h0000_2000, 20'h00067, 8'h89, 4'h0);
        put_desc(GB + 32, 32'h0001_0000, 20'h0FFFF, 8'h9A, 4'h4);
        put_desc(GB + 40, 32'h0002_0000, 20'h00FFF, 8'h13, 4'h4);
        put_desc(GB + 56, 32'hDEAD_0000, 20'h00010, 8'h92, 4'h0);
        put_desc(LB,      32'h0055_AA00, 20'h01234, 8'hF3, 4'h4);
        put_desc(LB + 8,  32'h0000_3000, 20'h00067, 8'h89, 4'h0);
        put_desc(LB + 16, 32'h0000_4000, 20'h00FFF, 8'h1A, 4'h0);
        put_desc(LB + 24, 32'h0000_5000, 20'h000FF, 8'h02, 4'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset done",  64'(ld_done), 64'd0);
        chk("reset fault", 64'(ld_fault), 64'd0);
        chk("reset base",  64'(seg_base[31:0]), 64'd0);

        do_load("R1 R8 gdt1 reg1",  16'h0009, 1, 3'd0, 32'h1234_5678, 20'h0ABCD, 8'h93, 4'h4);
        do_load("R8 gran gdt2 reg3", 16'h0010, 3, 3'd0, 32'hA000_0000, 20'hFFFFF, 8'h93, 4'hC);
        do_load("R3 ldt0 reg2",     16'h0007, 2, 3'd0, 32'h0055_AA00, 20'h01234, 8'hF3, 4'h4);
        do_load("R2 null reg1",     16'h0003, 1, 3'd1, '0, '0, '0, '0);
        do_load("R4 gdt8 range",    16'h0040, 1, 3'd2, '0, '0, '0, '0);
        do_load("R4 ldt4 range",    16'h0024, 2, 3'd2, '0, '0, '0, '0);
        do_load("R4 gdt7 edge ok",  16'h0038, 3, 3'd0, 32'hDEAD_0000, 20'h00010, 8'h92, 4'h0);
        do_load("R5 ldt tss",       16'h000C, 1, 3'd3, '0, '0, '0, '0);
        do_load("R5 gdt tss ok",    16'h0018, 1, 3'd0, 32'h0000_2000, 20'h00067, 8'h89, 4'h0);
        do_load("R6 exec wr reg2",  16'h0020, 2, 3'd4, '0, '0, '0, '0);
        do_load("R6 exec reg0",     16'h0020, 0, 3'd0, 32'h0001_0000, 20'h0FFFF, 8'h9A, 4'h4);
        do_load("R7 absent",        16'h0028, 3, 3'd5, '0, '0, '0, '0);
        do_load("R7 prio exec",     16'h0014, 2, 3'd4, '0, '0, '0, '0);
        do_load("R7 prio table",    16'h001C, 2, 3'd3, '0, '0, '0, '0);

        do_load("R12 load",         16'h0009, 1, 3'd0, 32'h1234_5678, 20'h0ABCD, 8'h93, 4'h4);
        put_desc(GB + 8, 32'h7777_0000, 20'h00042, 8'h92, 4'h0);
        repeat (4) @(negedge clk);
        chk("R12 base held",  64'(seg_base[63:32]),  64'h1234_5678);
        chk("R12 limit held", 64'(seg_limit[63:32]), 64'h0000_ABCD);
        do_load("R12 reload",       16'h0009, 1, 3'd0, 32'h7777_0000, 20'h00042, 8'h92, 4'h0);

        chk("R10 scoreboard empty", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule